// File: doc/BRIEF.md
# Periodic Rate and Square-Wave Generator

This block turns a slow reference waveform of nominally 32.768 kHz into a selectable periodic event. The reference arrives as a level on `ref_in`, synchronous to the fast system clock `clk`. Each transition of that level, rising or falling, advances a binary divider chain by one. A 4-bit rate code picks one bit of the chain as the wave. The wave drives a single-cycle tick for the interrupt logic and, when enabled, a square-wave pin with a 50% duty cycle.

A 3-bit divider-control field either lets the chain count or clears it and holds it at zero. Rate code 0 silences the output. All other codes give 32768 / 2^(code-1) Hz, from 32.768 kHz at code 1 down to 2 Hz at code 15. The wave register changes only on reference transitions. Because of this, a change of rate code is seen at the next transition of the reference, and no level of the wave can be shorter than one reference half-period.

Top module: `rtc_rate_gen`

## Requirements
- R1: With divider control not in reset and rate code c in 1..15, the wave equals bit (c-1) of the count of reference transitions since the chain was last cleared. That count is a 15-bit counter that wraps. The output frequency is therefore 32768 / 2^(c-1) Hz, and one output period spans 2^c reference transitions.
- R2: With rate code 0, the wave and `sqw_o` are low and `tick_o` stays low from the next clock edge on. The chain keeps counting.
- R3: Divider-control values 3'b110 and 3'b111 clear the chain to zero and hold it there. Under these values the wave stays low and no tick is issued. Every other value, including 3'b010, lets the chain run.
- R4: After the divider control leaves reset, the chain starts from zero. With rate code c, the first tick comes on the 2^(c-1)-th reference transition.
- R5: `tick_o` is high for exactly one `clk` cycle. That cycle is the one in which the wave goes from low to high.
- R6: `sqw_o` equals the wave while `sq_en` is high and is low while `sq_en` is low.
- R7: A change of the rate code between reference transitions leaves the wave unchanged until the next transition. The one exception is a change to code 0, which takes effect at once under R2.
- R8: While `rst_n` is low, `tick_o` and `sqw_o` are low and the chain is cleared.
- R9: A transition of `ref_in` is taken at the first rising `clk` edge at which `ref_in` differs from its registered copy. The wave and the tick update at that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the reference |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | 32.768 kHz reference level, synchronous to clk |
| rate_sel | input | 4 | Rate code: 0 off, 1..15 select a chain tap |
| div_ctl | input | 3 | Divider control: 3'b110 and 3'b111 hold the chain in reset |
| sq_en | input | 1 | Square-wave pin enable |
| tick_o | output | 1 | One-cycle pulse on each rising edge of the wave |
| sqw_o | output | 1 | Square-wave pin, gated by sq_en |

## Verification
The assertions check four things on every cycle. A held divider leaves the chain at zero. A silenced or held block drives no wave and no tick. Every tick coincides with a low-to-high step of the wave and lasts a single cycle. The wave never moves on a cycle without a reference transition. The bench scenarios are needed for the rest: the exact tap picked by each rate code, the distance to the first tick after divider reset, the frequency at the slowest code, and the behaviour when the rate code changes mid-period. These depend on counting reference transitions against a model that keeps its own count.

// File: rtl/rtc_rate_pkg.sv
package rtc_rate_pkg;

  // Divider control values whose two upper bits are both set hold the chain in reset.
  function automatic logic div_is_held(input logic [2:0] ctl);
    return ctl[2] & ctl[1];
  endfunction

  // Chain bit index that produces the wave for a nonzero rate code.
  function automatic int unsigned tap_of_code(input int unsigned code);
    return (code == 0) ? 0 : code - 1;
  endfunction

endpackage

// File: rtl/rtc_ref_edge.sv
module rtc_ref_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  output logic step_o
);
  logic ref_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ref_q <= 1'b0;
    else        ref_q <= ref_in;
  end

  // Either transition of the reference is one chain step.
  assign step_o = ref_in ^ ref_q;
endmodule

// File: rtl/rtc_div_chain.sv
module rtc_div_chain #(
  parameter int unsigned W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         adv,
  output logic [W-1:0] count_q,
  output logic [W-1:0] count_nxt
);
  always_comb begin
    if (clear)    count_nxt = '0;
    else if (adv) count_nxt = count_q + W'(1);
    else          count_nxt = count_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_nxt;
  end
endmodule

// File: rtl/rtc_tap_out.sv
module rtc_tap_out #(
  parameter int unsigned W     = 15,
  parameter int unsigned SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     count_nxt,
  input  logic [SEL_W-1:0] sel,
  input  logic             adv,
  input  logic             off,
  output logic             wave_o,
  output logic             tick_o
);
  import rtc_rate_pkg::*;

  logic tap_bit;

  always_comb begin
    tap_bit = 1'b0;
    for (int unsigned i = 0; i < W; i++) begin
      if (tap_of_code(int'(sel)) == i) tap_bit = count_nxt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wave_o <= 1'b0;
      tick_o <= 1'b0;
    end else if (off) begin
      wave_o <= 1'b0;
      tick_o <= 1'b0;
    end else if (adv) begin
      wave_o <= tap_bit;
      tick_o <= tap_bit & ~wave_o;
    end else begin
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_rate_gen.sv
module rtc_rate_gen #(
  parameter int unsigned RATE_W = 4,
  parameter int unsigned DIV_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_in,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic [DIV_W-1:0]  div_ctl,
  input  logic              sq_en,
  output logic              tick_o,
  output logic              sqw_o
);
  import rtc_rate_pkg::*;

  localparam int unsigned CHAIN_W = (1 << RATE_W) - 1;

  logic               step;
  logic               held;
  logic               off;
  logic               wave;
  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_nxt;

  assign held = div_is_held(3'(div_ctl));
  assign off  = held | (rate_sel == '0);

  rtc_ref_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .ref_in (ref_in),
    .step_o (step)
  );

  rtc_div_chain #(.W(CHAIN_W)) u_chain (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (held),
    .adv       (step),
    .count_q   (chain_q),
    .count_nxt (chain_nxt)
  );

  rtc_tap_out #(.W(CHAIN_W), .SEL_W(RATE_W)) u_tap (
    .clk       (clk),
    .rst_n     (rst_n),
    .count_nxt (chain_nxt),
    .sel       (rate_sel),
    .adv       (step),
    .off       (off),
    .wave_o    (wave),
    .tick_o    (tick_o)
  );

  assign sqw_o = wave & sq_en;
endmodule

// File: rtl/rtc_rate_gen_chk.sv
module rtc_rate_gen_chk #(
  parameter int unsigned W = 15
) (
  input logic         clk,
  input logic         rst_n,
  input logic         step,
  input logic         held,
  input logic         off,
  input logic         wave,
  input logic         tick_o,
  input logic [W-1:0] chain_q
);
  AST_HELD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    held |=> (chain_q == '0)); // R3

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    off |=> (!wave && !tick_o)); // R2

  AST_TICK_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> (wave && !$past(wave))); // R5

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o); // R5

  AST_WAVE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !off) |=> $stable(wave)); // R7
endmodule

bind rtc_rate_gen rtc_rate_gen_chk #(.W(CHAIN_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .step    (step),
  .held    (held),
  .off     (off),
  .wave    (wave),
  .tick_o  (tick_o),
  .chain_q (chain_q)
);

// File: tb/rtc_rate_gen_tb_top.sv
`timescale 1ns/1ps
module rtc_rate_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_in = 1'b0;
  logic [3:0] rate_sel = 4'd0;
  logic [2:0] div_ctl = 3'b110;
  logic       sq_en = 1'b0;
  logic       tick_o;
  logic       sqw_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // Bench model state
  int unsigned m_cnt  = 0;
  bit          m_wave = 1'b0;
  bit          m_tick = 1'b0;
  int          tick_seen = 0;

  always #2 clk = ~clk;

  rtc_rate_gen dut_i (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .rate_sel(rate_sel),
    .div_ctl(div_ctl), .sq_en(sq_en), .tick_o(tick_o), .sqw_o(sqw_o)
  );

  function automatic bit held_code(input logic [2:0] d);
    return (d == 3'd6) || (d == 3'd7);
  endfunction

  function automatic bit wave_for(input int unsigned cnt, input int unsigned code);
    if (code == 0) return 1'b0;
    return ((cnt >> (code - 1)) & 1) != 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_outputs(input string req);
    check({req, " tick"}, int'(tick_o), int'(m_tick));
    check({req, " R6 pin"}, int'(sqw_o), int'(m_wave & sq_en));
  endtask

  // One reference transition; outputs move at the first clk edge after it (R9).
  task automatic ref_step(input string req);
    @(negedge clk);
    ref_in = ~ref_in;
    @(posedge clk); #1;
    if (held_code(div_ctl)) begin
      m_cnt = 0; m_wave = 1'b0; m_tick = 1'b0;
    end else begin
      bit nw;
      m_cnt  = (m_cnt + 1) & 32'h7FFF;
      nw     = wave_for(m_cnt, rate_sel);
      m_tick = nw & ~m_wave;
      m_wave = nw;
    end
    if (tick_o) tick_seen++;
    check_outputs({req, " R9 R1"});
    @(posedge clk); #1;
    m_tick = 1'b0;
    check_outputs({req, " R5 single"});
  endtask

  task automatic set_ctl(input logic [3:0] code, input logic [2:0] d, input logic en);
    @(negedge clk);
    rate_sel = code; div_ctl = d; sq_en = en;
    @(posedge clk); #1;
    if (held_code(d)) begin
      m_cnt = 0; m_wave = 1'b0;
    end else if (code == 0) begin
      m_wave = 1'b0;
    end
    m_tick = 1'b0;
    check_outputs("R7 R2 R3 ctl");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R8: reset state
    sq_en = 1'b1; rate_sel = 4'd1; div_ctl = 3'b010;
    repeat (3) @(posedge clk);
    @(negedge clk); ref_in = 1'b1;
    @(negedge clk);
    check("R8 tick in reset", int'(tick_o), 0);
    check("R8 pin in reset", int'(sqw_o), 0);
    ref_in = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    m_cnt = 0; m_wave = 0; m_tick = 0;

    // R1: fastest rate, wave toggles on every transition
    for (int i = 0; i < 8; i++) ref_step("R1 code1");

    // R3: held chain, transitions ignored
    set_ctl(4'd3, 3'b111, 1'b1);
    for (int i = 0; i < 6; i++) ref_step("R3 held");
    check("R3 held pin", int'(sqw_o), 0);

    // R4: first tick after 2^(c-1) transitions from divider release
    set_ctl(4'd4, 3'b010, 1'b1);
    tick_seen = 0;
    for (int i = 0; i < 7; i++) ref_step("R4 pre");
    check("R4 no tick before 8 edges", tick_seen, 0);
    ref_step("R4 first");
    check("R4 tick on 8th edge", tick_seen, 1);

    // R2: code 0 silences output while chain keeps counting
    set_ctl(4'd0, 3'b010, 1'b1);
    for (int i = 0; i < 5; i++) ref_step("R2 off");
    check("R2 pin low", int'(sqw_o), 0);

    // R6: enable gating
    set_ctl(4'd1, 3'b010, 1'b0);
    for (int i = 0; i < 4; i++) ref_step("R6 gated");

    // R7: code change mid-period keeps the wave until the next transition
    set_ctl(4'd2, 3'b010, 1'b1);
    for (int i = 0; i < 3; i++) ref_step("R7 pre");
    set_ctl(4'd5, 3'b010, 1'b1);
    check("R7 wave held after code change", int'(sqw_o), int'(m_wave));
    ref_step("R7 post");

    // R1: slowest rate, first tick after 16384 transitions
    set_ctl(4'd15, 3'b110, 1'b1);
    set_ctl(4'd15, 3'b010, 1'b1);
    tick_seen = 0;
    for (int i = 0; i < 16384; i++) ref_step("R1 code15");
    check("R1 code15 one tick", tick_seen, 1);

    // R1: tick count over four periods at code 3
    set_ctl(4'd3, 3'b110, 1'b1);
    set_ctl(4'd3, 3'b010, 1'b1);
    tick_seen = 0;
    for (int i = 0; i < 32; i++) ref_step("R1 code3");
    check("R1 code3 four ticks", tick_seen, 4);

    // Constrained random mix
    for (int k = 0; k < 60; k++) begin
      logic [3:0] c;
      logic [2:0] d;
      int n;
      c = 4'($urandom_range(0, 7));
      d = ($urandom_range(0, 5) == 0) ? 3'($urandom_range(6, 7)) : 3'($urandom_range(0, 5));
      set_ctl(c, d, 1'($urandom_range(0, 1)));
      n = $urandom_range(1, 40);
      for (int i = 0; i < n; i++) ref_step("R1 R7 random");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule